// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block ends an I2C master transfer by placing a stop condition on the bus. When software raises the stop request, the sequencer pulls SDA low while SCL is held low. It then releases SCL and, last, releases SDA. A reloadable baud down-counter paces each step. No step goes ahead until the sampled bus line shows that the previous step has taken effect. A device that holds a line low therefore stalls the sequence without breaking it.

Beside the sequencer, a line monitor finds start and stop conditions on the sampled lines. From these it keeps a start-seen flag, which also serves as bus-busy, a stop-seen flag and a one-cycle bus-free pulse. An interrupt flag is set one baud period after the stop is detected, in the same edge that drops the active indication. A transmit-buffer write port refuses writes while a sequence runs and raises a write-collision flag.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset both line drivers are released (`scl_pull_low` and `sda_pull_low` are 0), `stop_active`, `stop_seen`, `start_seen`, `bus_busy`, `bus_free_pulse`, `irq_flag` and `wcol` are 0, and `txbuf_q` is 0.
- R2: A `stop_req` sampled high while idle sets `stop_active`, `sda_pull_low` and `scl_pull_low` on that same edge.
- R3: The edge that releases SCL comes exactly `brg_reload`+1 clock edges after the first edge at which the sequencer sees SDA sampled low. One input register sits between the bus pins and that sampled view. With no stretching, SCL is released 3+`brg_reload` cycles after the edge that accepted the request. SDA stays driven low while SCL is released.
- R4: SDA is released `brg_reload`+1 edges after the sequencer sees SCL sampled high. If another device holds SCL low for extra cycles, every later step moves by the same number of cycles. With no stretching, SDA is released 6+2×`brg_reload` cycles after acceptance.
- R5: A stop condition is SDA sampled rising while SCL is sampled high on both of the last two samples. It sets `stop_seen`, clears `start_seen` and pulses `bus_free_pulse` for one cycle. A start condition is SDA sampled falling under the same SCL rule. It sets `start_seen` and `bus_busy` and clears `stop_seen`.
- R6: `brg_reload`+1 edges after the stop is detected, `stop_active` falls and `irq_flag` is set on the same edge. `irq_flag` stays at 1 until `irq_clr` is pulsed.
- R7: A `txbuf_we` while `stop_active` is 1 leaves `txbuf_q` unchanged and sets `wcol`, which holds until `wcol_clr`. A write while idle loads `txbuf_wdata` into `txbuf_q`.
- R8: If SDA is held low by another device after the sequencer releases it, the sequencer waits. The stop detection and the completion are each delayed by exactly the extra hold cycles.
- R9: A `stop_req` that arrives while a sequence is active is ignored and does not change the timing of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_reload | input | BRG_W | Baud reload value; one period is this value plus one cycles |
| stop_req | input | 1 | Software request to begin a stop sequence |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| stop_active | output | 1 | Stop sequence in progress (request bit readback) |
| stop_seen | output | 1 | Stop condition detected since last start |
| start_seen | output | 1 | Start condition detected since last stop |
| bus_busy | output | 1 | Bus owned by some master |
| bus_free_pulse | output | 1 | One-cycle notification that a stop was detected |
| irq_flag | output | 1 | Sequence-complete interrupt flag |
| irq_clr | input | 1 | Clears irq_flag |
| txbuf_we | input | 1 | Transmit buffer write strobe |
| txbuf_wdata | input | DATA_W | Transmit buffer write data |
| txbuf_q | output | DATA_W | Transmit buffer contents |
| wcol | output | 1 | Write collision flag |
| wcol_clr | input | 1 | Clears wcol |

## Verification
The hardest case to reach is a sequence in which another device stretches SCL and then also holds SDA low past the sequencer's own release. Each delay must push only the later steps, and by exactly its own length. The bench drives open-drain lines with extra hold signals and releases them at chosen cycles after the sequencer lets go. A scoreboard then compares the time of every bus step against offsets computed from the reload value and the two hold lengths. In one run a buffer write and a second stop request are also issued mid-sequence, to show that both are refused.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LO,
    ST_WAIT1,
    ST_SCL_HI,
    ST_WAIT2,
    ST_SDA_HI,
    ST_WAIT3
  } stop_state_e;

  // cycles in one baud period for a given reload value
  function automatic int unsigned brg_cycles(input int unsigned reload);
    return reload + 1;
  endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q, scl_qq, sda_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      scl_qq <= 1'b1;
      sda_qq <= 1'b1;
    end else begin
      scl_q  <= scl_in;
      sda_q  <= sda_in;
      scl_qq <= scl_q;
      sda_qq <= sda_q;
    end
  end

  assign scl_s     = scl_q;
  assign sda_s     = sda_q;
  assign start_det = scl_q & scl_qq & sda_qq & ~sda_q;
  assign stop_det  = scl_q & scl_qq & ~sda_qq & sda_q;
endmodule

// File: rtl/i2c_brg.sv
module i2c_brg #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BRG_W-1:0] reload,
  output logic             expired
);
  logic [BRG_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= reload;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
  import i2c_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic scl_s,
  input  logic sda_s,
  input  logic stop_det,
  input  logic brg_expired,
  output logic brg_load,
  output logic brg_fire,
  output logic done_pulse,
  output logic busy,
  output logic scl_low,
  output logic sda_low
);
  stop_state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  logic timed;
  assign timed = (state == ST_WAIT1) || (state == ST_WAIT2) || (state == ST_WAIT3);

  always_comb begin
    nxt      = state;
    brg_load = 1'b0;
    unique case (state)
      ST_IDLE:   if (stop_req) nxt = ST_SDA_LO;
      ST_SDA_LO: if (!sda_s) begin nxt = ST_WAIT1; brg_load = 1'b1; end
      ST_WAIT1:  if (brg_expired) nxt = ST_SCL_HI;
      ST_SCL_HI: if (scl_s) begin nxt = ST_WAIT2; brg_load = 1'b1; end
      ST_WAIT2:  if (brg_expired) nxt = ST_SDA_HI;
      ST_SDA_HI: if (stop_det) begin nxt = ST_WAIT3; brg_load = 1'b1; end
      ST_WAIT3:  if (brg_expired) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign brg_fire   = timed & brg_expired;
  assign done_pulse = (state == ST_WAIT3) & brg_expired;
  assign busy       = (state != ST_IDLE);
  assign scl_low    = (state == ST_SDA_LO) || (state == ST_WAIT1);
  assign sda_low    = scl_low || (state == ST_SCL_HI) || (state == ST_WAIT2);
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BRG_W-1:0]  brg_reload,
  input  logic              stop_req,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull_low,
  output logic              sda_pull_low,
  output logic              stop_active,
  output logic              stop_seen,
  output logic              start_seen,
  output logic              bus_busy,
  output logic              bus_free_pulse,
  output logic              irq_flag,
  input  logic              irq_clr,
  input  logic              txbuf_we,
  input  logic [DATA_W-1:0] txbuf_wdata,
  output logic [DATA_W-1:0] txbuf_q,
  output logic              wcol,
  input  logic              wcol_clr
);
  // internal events, named for the checker
  logic scl_s, sda_s, start_det, stop_det;
  logic brg_load, brg_fire, brg_expired, done_pulse, busy;

  i2c_line_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_brg #(.BRG_W(BRG_W)) u_brg (
    .clk(clk), .rst_n(rst_n), .load(brg_load), .reload(brg_reload),
    .expired(brg_expired)
  );

  i2c_stop_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .scl_s(scl_s),
    .sda_s(sda_s), .stop_det(stop_det), .brg_expired(brg_expired),
    .brg_load(brg_load), .brg_fire(brg_fire), .done_pulse(done_pulse),
    .busy(busy), .scl_low(scl_pull_low), .sda_low(sda_pull_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_seen      <= 1'b0;
      start_seen     <= 1'b0;
      bus_free_pulse <= 1'b0;
      irq_flag       <= 1'b0;
      wcol           <= 1'b0;
      txbuf_q        <= '0;
    end else begin
      bus_free_pulse <= stop_det;
      if (stop_det) begin
        stop_seen  <= 1'b1;
        start_seen <= 1'b0;
      end else if (start_det) begin
        stop_seen  <= 1'b0;
        start_seen <= 1'b1;
      end
      if (done_pulse)   irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
      if (txbuf_we && busy) wcol <= 1'b1;
      else if (wcol_clr)    wcol <= 1'b0;
      if (txbuf_we && !busy) txbuf_q <= txbuf_wdata;
    end
  end

  assign stop_active = busy;
  assign bus_busy    = start_seen;
endmodule

// File: rtl/i2c_stop_seq_chk.sv
module i2c_stop_seq_chk
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BRG_W-1:0]  brg_reload,
  input logic              stop_req,
  input logic              scl_pull_low,
  input logic              sda_pull_low,
  input logic              stop_active,
  input logic              stop_seen,
  input logic              bus_free_pulse,
  input logic              irq_flag,
  input logic              txbuf_we,
  input logic [DATA_W-1:0] txbuf_q,
  input logic              wcol,
  input logic              brg_load,
  input logic              brg_fire
);
  logic [BRG_W:0] win_cnt;
  logic [31:0]    win_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     win_cnt <= '0;
    else if (brg_load)              win_cnt <= '0;
    else if (win_cnt != '1)         win_cnt <= win_cnt + 1'b1;
  end
  assign win_cycles = 32'(win_cnt) + 32'd1;

  p_setup_sda_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> (sda_pull_low && scl_pull_low));

  p_brg_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brg_fire |-> (win_cycles == brg_cycles(32'(brg_reload))));

  p_scl_rel_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_low) |-> sda_pull_low);

  p_sda_rel_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_low) |-> (!scl_pull_low && stop_active));

  p_free_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_pulse |-> stop_seen);

  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_active) |-> irq_flag);

  p_wcol_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_we && stop_active) |=> (wcol && $stable(txbuf_q)));

  p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && sda_pull_low && stop_req) |=> stop_active);
endmodule

bind i2c_stop_seq i2c_stop_seq_chk #(.BRG_W(BRG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .stop_req(stop_req),
  .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
  .stop_active(stop_active), .stop_seen(stop_seen),
  .bus_free_pulse(bus_free_pulse), .irq_flag(irq_flag),
  .txbuf_we(txbuf_we), .txbuf_q(txbuf_q), .wcol(wcol),
  .brg_load(brg_load), .brg_fire(brg_fire)
);

// File: tb/sim_i2c_stop_seq.sv
module sim_i2c_stop_seq;
  localparam int BW = 8;
  localparam int DW = 8;
  localparam int EV_SDA_LO = 1, EV_SCL_REL = 2, EV_SDA_REL = 3, EV_STOP = 4, EV_DONE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] brg_reload = '0;
  logic stop_req = 1'b0, irq_clr = 1'b0, txbuf_we = 1'b0, wcol_clr = 1'b0;
  logic [DW-1:0] txbuf_wdata = '0;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic scl_in, sda_in;
  logic scl_pull_low, sda_pull_low, stop_active, stop_seen, start_seen;
  logic bus_busy, bus_free_pulse, irq_flag, wcol;
  logic [DW-1:0] txbuf_q;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit mon_en = 1'b0;
  int exp_code[$];
  int exp_cyc[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = ~(scl_pull_low | ext_scl_low);
  assign sda_in = ~(sda_pull_low | ext_sda_low);

  i2c_stop_seq #(.BRG_W(BW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .stop_req(stop_req),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull_low(scl_pull_low),
    .sda_pull_low(sda_pull_low), .stop_active(stop_active),
    .stop_seen(stop_seen), .start_seen(start_seen), .bus_busy(bus_busy),
    .bus_free_pulse(bus_free_pulse), .irq_flag(irq_flag), .irq_clr(irq_clr),
    .txbuf_we(txbuf_we), .txbuf_wdata(txbuf_wdata), .txbuf_q(txbuf_q),
    .wcol(wcol), .wcol_clr(wcol_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: detect bus steps and compare against the expected queue
  logic p_scl, p_sda, p_act, p_free;
  task automatic mon_event(input int code, input string req);
    if (exp_code.size() == 0) begin
      check(1'b0, req, code, 0);
    end else begin
      int c = exp_code.pop_front();
      int t = exp_cyc.pop_front();
      check(c == code, req, code, c);
      check(cyc == t, req, cyc, t);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (sda_pull_low && !p_sda) mon_event(EV_SDA_LO, "R2 sda pulled low");
      if (!scl_pull_low && p_scl) mon_event(EV_SCL_REL, "R3 scl release time");
      if (!sda_pull_low && p_sda) mon_event(EV_SDA_REL, "R4 sda release time");
      if (bus_free_pulse && !p_free) begin
        mon_event(EV_STOP, "R5 stop detect time");
        check(stop_seen == 1'b1, "R5 stop_seen with pulse", int'(stop_seen), 1);
      end
      if (!stop_active && p_act) begin
        mon_event(EV_DONE, "R6 completion time");
        check(irq_flag == 1'b1, "R6 irq at completion", int'(irq_flag), 1);
      end
    end
    p_scl  = scl_pull_low;
    p_sda  = sda_pull_low;
    p_act  = stop_active;
    p_free = bus_free_pulse;
  end

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // driver: schedules expected steps, then plays the other bus devices
  task automatic run_stop(input int r, input int s_scl, input int s_sda, input bit poke);
    int base;
    logic [DW-1:0] keep;
    brg_reload = BW'(r);
    if (s_scl > 0) ext_scl_low = 1'b1;
    @(negedge clk);
    stop_req = 1'b1;
    base = cyc + 1;
    exp_code.push_back(EV_SDA_LO);  exp_cyc.push_back(base);
    exp_code.push_back(EV_SCL_REL); exp_cyc.push_back(base + 3 + r);
    exp_code.push_back(EV_SDA_REL); exp_cyc.push_back(base + 6 + 2*r + s_scl);
    exp_code.push_back(EV_STOP);    exp_cyc.push_back(base + 8 + 2*r + s_scl + s_sda);
    exp_code.push_back(EV_DONE);    exp_cyc.push_back(base + 9 + 3*r + s_scl + s_sda);
    mon_en = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    if (s_sda > 0) ext_sda_low = 1'b1;
    if (poke) begin
      keep = txbuf_q;
      wait_until(base + 2);
      txbuf_we = 1'b1; txbuf_wdata = ~keep; stop_req = 1'b1;  // R7 and R9 stimulus
      @(negedge clk);
      txbuf_we = 1'b0; stop_req = 1'b0;
      check(wcol == 1'b1, "R7 wcol on busy write", int'(wcol), 1);
      check(txbuf_q == keep, "R7 buffer unchanged", int'(txbuf_q), int'(keep));
      check(stop_active == 1'b1, "R9 request ignored", int'(stop_active), 1);
    end
    wait_until(base + 3 + r + s_scl);
    ext_scl_low = 1'b0;
    wait_until(base + 6 + 2*r + s_scl + s_sda);
    ext_sda_low = 1'b0;
    wait_until(base + 12 + 3*r + s_scl + s_sda);
    mon_en = 1'b0;
    check(exp_code.size() == 0, "R6 all steps seen", exp_code.size(), 0);
    check(stop_active == 1'b0, "R6 sequence finished", int'(stop_active), 0);
    check(irq_flag == 1'b1, "R6 irq held", int'(irq_flag), 1);
    check(!scl_pull_low && !sda_pull_low, "R4 lines released",
          int'({scl_pull_low, sda_pull_low}), 0);
    exp_code.delete();
    exp_cyc.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!scl_pull_low && !sda_pull_low, "R1 drivers released",
          int'({scl_pull_low, sda_pull_low}), 0);
    check(!stop_active && !stop_seen && !start_seen && !bus_busy, "R1 status clear",
          int'({stop_active, stop_seen, start_seen, bus_busy}), 0);
    check(!irq_flag && !wcol && !bus_free_pulse && txbuf_q == '0, "R1 flags clear",
          int'({irq_flag, wcol, bus_free_pulse}), 0);

    // R7 idle write goes through
    txbuf_we = 1'b1; txbuf_wdata = 8'hA5;
    @(negedge clk);
    txbuf_we = 1'b0;
    check(txbuf_q == 8'hA5, "R7 idle write", int'(txbuf_q), 'hA5);
    check(wcol == 1'b0, "R7 no collision idle", int'(wcol), 0);

    // main sequence with mid-sequence write and repeated request
    run_stop(3, 0, 0, 1'b1);
    check(stop_seen == 1'b1, "R5 stop_seen set", int'(stop_seen), 1);
    check(txbuf_q == 8'hA5, "R7 buffer kept", int'(txbuf_q), 'hA5);
    repeat (3) @(negedge clk);
    check(irq_flag && wcol, "R6 R7 flags sticky", int'({irq_flag, wcol}), 3);
    irq_clr = 1'b1; wcol_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; wcol_clr = 1'b0;
    check(!irq_flag && !wcol, "R6 R7 flags cleared", int'({irq_flag, wcol}), 0);

    // R5 start condition from another master, then its stop
    ext_sda_low = 1'b1;
    repeat (3) @(negedge clk);
    check(start_seen && bus_busy, "R5 start seen", int'({start_seen, bus_busy}), 3);
    check(stop_seen == 1'b0, "R5 start clears stop", int'(stop_seen), 0);
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    check(stop_seen && !start_seen && !bus_busy, "R5 bus free",
          int'({stop_seen, start_seen, bus_busy}), 4);

    // R3 boundary: zero reload
    run_stop(0, 0, 0, 1'b0);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    // R4 SCL stretched by another device
    run_stop(5, 4, 0, 1'b0);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    // R8 SDA held after release, plus stretch and busy write
    run_stop(2, 2, 3, 1'b1);
    check(wcol == 1'b1, "R7 wcol after second run", int'(wcol), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule